// File: doc/BRIEF.md
# Alternating Pulse Steering State Machine

This block takes one stream of positive pulses and hands them out in turn to two active-low outputs. The first pulse after reset goes to output A, the next to output B, and so on. Each output stays low for a time that follows the width of the input pulse that caused it. The two outputs drive the gates of a complementary pair of power switches in a resonant clock generator, so they must never be low together.

The sequencer holds four state bits (x, y, a, b) and moves through a ring of eight codes. Each step changes exactly one bit. The model is synchronous: the pulse input passes through a synchroniser, and the machine takes at most one single-bit step per system clock. It keeps stepping until it reaches the stable code for the current input level. Input high and low phases must each last at least two system clocks. Shorter phases do not give the machine time to settle and are not supported.

Top module: `pulse_steer`

## Requirements
- R1: A synchronous reset, high at a clock edge, sets the state to x,y,a,b = 1011 and holds `a_n` and `b_n` high. With the default two-stage synchroniser, it also clears the synchroniser, so an input pulse that was high during reset is not seen.
- R2: The first input pulse after reset produces a low pulse on `a_n`. After that, pulses go to `b_n` and `a_n` in strict alternation.
- R3: With the default two-stage synchroniser, the output goes low on the third rising clock edge after the input rises. An input held high for W clocks (W at least 2) gives an output low for exactly W+1 clocks.
- R4: Every change of `state_bits` flips exactly one bit.
- R5: `state_bits` (bit 3 = x, bit 2 = y, bit 1 = a, bit 0 = b) only takes the codes in the ring 1011, 1001, 1101, 0101, 0111, 0110, 1110, 1010. It only ever moves to the next code in that ring.
- R6: `a_n` and `b_n` are never low in the same cycle.
- R7: `gate_n` is always the inverse of `a_n`. `gate_p` always equals `b_n`, because it passes through an even number of inversions.
- R8: While the input level stays constant, the state stops at a stable code and does not change. The stable codes are 1011 or 0111 for a low input, and 1101 or 1110 for a high input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pulse input |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Input pulse stream, positive pulses |
| state_bits | output | 4 | Current state code {x,y,a,b} |
| a_n | output | 1 | Active-low steered pulse, first side |
| b_n | output | 1 | Active-low steered pulse, second side |
| gate_n | output | 1 | Gate drive for the NMOS switch, the inverse of a_n |
| gate_p | output | 1 | Gate drive for the PMOS switch, in phase with b_n |

## Verification
The bench uses the shortest legal pulses and gaps, two clocks each. A design that moves to the next code too early or too late at that spacing would stretch or lose a pulse, or steer two pulses in a row to the same side. It also uses long pulses and long idle periods: a machine that does not stop at its stable code would drift through the ring and drop both outputs on its own. Every output pulse is checked for side, start cycle and width, against W+1. An off-by-one in the synchroniser depth or in the release step shows up as a width or latency mismatch. One reset is applied in the middle of an active pulse: a design that holds its old state or keeps a stale synchronised level would leave an output low or send the next pulse to B.

// File: rtl/pulse_steer_pkg.sv
package pulse_steer_pkg;

   typedef logic [3:0] code_t;

   // bit positions inside a state code
   localparam int unsigned BIT_X = 3;
   localparam int unsigned BIT_Y = 2;
   localparam int unsigned BIT_A = 1;
   localparam int unsigned BIT_B = 0;

   localparam code_t C_IDLE_LO_A = 4'b1011; // reset code, both outputs high
   localparam code_t C_A_LOW     = 4'b1001;
   localparam code_t C_A_HELD    = 4'b1101;
   localparam code_t C_A_REL     = 4'b0101;
   localparam code_t C_IDLE_LO_B = 4'b0111;
   localparam code_t C_B_LOW     = 4'b0110;
   localparam code_t C_B_HELD    = 4'b1110;
   localparam code_t C_B_REL     = 4'b1010;

   // next code in the ring, independent of input level
   function automatic code_t ring_next(input code_t s);
      case (s)
         C_IDLE_LO_A: ring_next = C_A_LOW;
         C_A_LOW:     ring_next = C_A_HELD;
         C_A_HELD:    ring_next = C_A_REL;
         C_A_REL:     ring_next = C_IDLE_LO_B;
         C_IDLE_LO_B: ring_next = C_B_LOW;
         C_B_LOW:     ring_next = C_B_HELD;
         C_B_HELD:    ring_next = C_B_REL;
         default:     ring_next = C_IDLE_LO_A;
      endcase
   endfunction

   // level that lets a code advance: 1 = needs high input, 0 = needs low
   function automatic logic advance_level(input code_t s);
      case (s)
         C_IDLE_LO_A, C_A_LOW, C_IDLE_LO_B, C_B_LOW: advance_level = 1'b1;
         default:                                    advance_level = 1'b0;
      endcase
   endfunction

   function automatic logic code_legal(input code_t s);
      case (s)
         C_IDLE_LO_A, C_A_LOW, C_A_HELD, C_A_REL,
         C_IDLE_LO_B, C_B_LOW, C_B_HELD, C_B_REL: code_legal = 1'b1;
         default:                                 code_legal = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/steer_sync.sv
module steer_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("steer_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[k] <= 1'b0;
            else     chain_q[k] <= chain_q[k-1];
         end
      end
   end

   assign q = chain_q[LAST];

endmodule

// File: rtl/steer_core.sv
module steer_core
   import pulse_steer_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  level,
   output code_t state_q
);
   code_t state_d;

   always_comb begin
      state_d = state_q;
      if (!code_legal(state_q))
         state_d = C_IDLE_LO_A;
      else if (level == advance_level(state_q))
         state_d = ring_next(state_q);
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= C_IDLE_LO_A;
      else     state_q <= state_d;
   end

   assert_one_bit_step_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q != $past(state_q)) |-> ($countones(state_q ^ $past(state_q)) == 1));

   assert_legal_code_R5: assert property (@(posedge clk) disable iff (rst)
      code_legal(state_q));

   assert_ring_order_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q != $past(state_q)) |-> (state_q == ring_next($past(state_q))));

   assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q[BIT_A] | state_q[BIT_B]));

   assert_hold_on_level_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(level) != advance_level($past(state_q))) |-> $stable(state_q));

endmodule

// File: rtl/steer_gate.sv
module steer_gate #(
   parameter int unsigned P_INV_STAGES = 2
) (
   input  logic a_n,
   input  logic b_n,
   output logic gate_n,
   output logic gate_p
);
   if ((P_INV_STAGES == 0) || (P_INV_STAGES % 2 != 0)) begin : g_bad_inv
      $error("steer_gate: P_INV_STAGES must be even and nonzero");
   end

   assign gate_n = ~a_n;

   for (genvar k = 0; k < P_INV_STAGES; k++) begin : g_inv
      logic s;
      if (k == 0) begin : g_head
         assign s = ~b_n;
      end else begin : g_tail
         assign s = ~g_inv[k-1].s;
      end
   end

   assign gate_p = g_inv[P_INV_STAGES-1].s;

endmodule

// File: rtl/pulse_steer.sv
module pulse_steer
   import pulse_steer_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned P_INV_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pulse_in,
   output logic [3:0] state_bits,
   output logic       a_n,
   output logic       b_n,
   output logic       gate_n,
   output logic       gate_p
);
   logic  level_s;
   code_t state_q;

   steer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pulse_in),
      .q   (level_s)
   );

   steer_core u_core (
      .clk     (clk),
      .rst     (rst),
      .level   (level_s),
      .state_q (state_q)
   );

   assign state_bits = state_q;
   assign a_n        = state_q[BIT_A];
   assign b_n        = state_q[BIT_B];

   steer_gate #(.P_INV_STAGES(P_INV_STAGES)) u_gate (
      .a_n    (a_n),
      .b_n    (b_n),
      .gate_n (gate_n),
      .gate_p (gate_p)
   );

   assert_gate_polarity_R7: assert property (@(posedge clk) disable iff (rst)
      (gate_n != a_n) && (gate_p == b_n));

   assert_reset_idle_R1: assert property (@(posedge clk)
      $past(rst) |-> (a_n && b_n));

endmodule

// File: tb/test_pulse_steer.sv
module test_pulse_steer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pulse_in = 1'b0;
   logic [3:0] state_bits;
   logic       a_n, b_n, gate_n, gate_p;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit sb_on = 1'b0;
   bit done = 1'b0;

   typedef struct { bit side; int width; int start; } item_t;
   item_t exp_q[$];
   bit next_side = 1'b0;

   pulse_steer i_pulse_steer (
      .clk(clk), .rst(rst), .pulse_in(pulse_in), .state_bits(state_bits),
      .a_n(a_n), .b_n(b_n), .gate_n(gate_n), .gate_p(gate_p)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [3:0] succ(input logic [3:0] s);
      logic [3:0] ring [8] = '{4'b1011, 4'b1001, 4'b1101, 4'b0101,
                               4'b0111, 4'b0110, 4'b1110, 4'b1010};
      succ = 4'b0000;
      for (int k = 0; k < 8; k++)
         if (ring[k] == s) succ = ring[(k + 1) % 8];
   endfunction

   // driver: one pulse of w high cycles then g low cycles
   task automatic send(input int w, input int g);
      item_t it;
      @(negedge clk);
      pulse_in = 1'b1;
      it.side = next_side; it.width = w + 1; it.start = cyc + 3;
      exp_q.push_back(it);
      next_side = ~next_side;
      repeat (w) @(negedge clk);
      pulse_in = 1'b0;
      repeat (g - 1) @(negedge clk);
   endtask

   // monitor
   logic [3:0] prev_state = 4'b1011;
   bit a_prev = 1'b1, b_prev = 1'b1;
   int a_start = 0, b_start = 0;

   task automatic close_run(input bit side, input int start);
      item_t it;
      if (exp_q.size() == 0) begin
         check(1'b0, "R2 unexpected output pulse", side, -1);
      end else begin
         it = exp_q.pop_front();
         check(it.side == side, "R2 side", side, it.side);
         check(it.start == start, "R3 start cycle", start, it.start);
         check(it.width == cyc - start, "R3 width", cyc - start, it.width);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         check(a_n | b_n, "R6 both low", {a_n, b_n}, 1);
         check((gate_n == ~a_n) && (gate_p == b_n), "R7 gate polarity",
               {gate_n, gate_p}, {~a_n, b_n});
         if (state_bits != prev_state) begin
            check($countones(state_bits ^ prev_state) == 1, "R4 one-bit step",
                  state_bits, prev_state);
            check(state_bits == succ(prev_state), "R5 ring order",
                  state_bits, succ(prev_state));
         end
         if (sb_on) begin
            if (a_prev && !a_n) a_start = cyc;
            if (!a_prev && a_n) close_run(1'b0, a_start);
            if (b_prev && !b_n) b_start = cyc;
            if (!b_prev && b_n) close_run(1'b1, b_start);
         end
      end
      prev_state = state_bits;
      a_prev = a_n;
      b_prev = b_n;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(state_bits == 4'b1011, "R1 reset code", state_bits, 4'b1011);
      check(a_n && b_n, "R1 outputs idle", {a_n, b_n}, 2'b11);
      rst = 1'b0;
      sb_on = 1'b1;

      // R2/R3: minimum spacing, mixed widths
      send(2, 2); send(2, 2); send(3, 4); send(5, 2);
      send(8, 3); send(2, 6); send(12, 2); send(4, 9);
      // R8: long idle after even count keeps the reset code
      repeat (20) @(negedge clk);
      check(state_bits == 4'b1011, "R8 idle hold low", state_bits, 4'b1011);
      send(6, 30);
      check(state_bits == 4'b0111, "R8 idle hold after B-side", state_bits, 4'b0111);
      // R8: long high input holds the held code
      @(negedge clk); pulse_in = 1'b1;
      exp_q.push_back('{side: next_side, width: 26, start: cyc + 3});
      next_side = ~next_side;
      repeat (10) @(negedge clk);
      check(state_bits == 4'b1110, "R8 hold while high", state_bits, 4'b1110);
      repeat (15) @(negedge clk);
      pulse_in = 1'b0;
      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);

      // R1: reset in the middle of an A pulse
      sb_on = 1'b0;
      pulse_in = 1'b1;
      repeat (5) @(negedge clk);
      check(a_n == 1'b0, "R3 A low before reset", a_n, 0);
      rst = 1'b1;
      @(negedge clk);
      check(state_bits == 4'b1011, "R1 mid-pulse reset code", state_bits, 4'b1011);
      check(a_n && b_n, "R1 mid-pulse outputs idle", {a_n, b_n}, 2'b11);
      pulse_in = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      pulse_in = 1'b1;
      repeat (3) @(negedge clk);
      check(!a_n && b_n, "R2 first pulse after reset on A", {a_n, b_n}, 2'b01);
      pulse_in = 1'b0;
      repeat (6) @(negedge clk);
      check(state_bits == 4'b0111, "R8 settle after A pulse", state_bits, 4'b0111);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule